// File: doc/BRIEF.md
# Dual-Slot Card Pin Event Unit

This unit watches the status pins of two card sockets. It samples them into one shared 32-bit pin register, turns pin movements into sticky event bits, and raises one interrupt line when an event bit is set and its enable bit is also set. Slot A owns the upper halfword of every register and slot B owns the lower halfword. Inside each halfword the bit positions are the same.

Software reads the pin register to see the present pin levels and whether a card is fully seated. It then reads the event register to learn what changed since the last read. It acknowledges events by writing ones to them. The ready pin has four event sources of its own:
- a live low-level flag,
- a sticky high-level flag,
- a rising-edge flag,
- a falling-edge flag.

The level flag lets a card that is busy hold the interrupt until the card itself releases it.

Top module: `slot_pin_event_unit`

## Requirements
- R1: The pin register (address 0) shows the synchronised slot A pins in bits 31:24 and the slot B pins in bits 15:8. Within each byte, from the top bit down, the order is VS1, VS2, WP, CD2, CD1, BVD2, BVD1, RDY. A pin change reaches the register after two clock edges.
- R2: Pin register bit 16 (slot A) and bit 0 (slot B) read 1 only when both card-detect pins of that slot sample low. Any mismatch reads 0.
- R3: A toggle on any pin sets the event bit at the same position in the event register (address 1), bits 31:24 or 15:8, one edge after the pin register shows the change.
- R4: A 0-to-1 change of RDY sets event bit 21 (slot A) or bit 5 (slot B). A 1-to-0 change sets bit 20 or bit 4.
- R5: Event bit 23 (slot A) and bit 7 (slot B) read 1 exactly while the synchronised RDY is low. Writes to these bits have no effect.
- R6: Event bit 22 (slot A) and bit 6 (slot B) are set on every edge at which the synchronised RDY is high. A clear of these bits therefore holds only once RDY is low.
- R7: Writing to address 1 clears each event bit written with a one and keeps each bit written with a zero. When a set and a clear reach the same bit on the same edge, the bit ends up set.
- R8: The enable register (address 2) is read/write across all 32 bits.
- R9: The irq output is registered. It is 1 one edge after any event bit reads 1 together with its enable bit, and 0 one edge after no such pair exists.
- R10: The synchronous active-low reset clears every register and irq. Edge events stay off until three edges after reset release, and level events and presence stay off until two edges after release.
- R11: Event bits 19:16 and 3:0, pin bits 23:17 and 7:1, and all of address 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_a | input | 8 | Slot A socket pins {VS1,VS2,WP,CD2,CD1,BVD2,BVD1,RDY}, asynchronous |
| pin_b | input | 8 | Slot B socket pins, same order, asynchronous |
| reg_addr | input | 2 | Register select: 0 pins, 1 events, 2 enable |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register, combinational |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest situation to reach is a software clear landing on the same edge at which a pin event sets that same bit. The event surfaces only after the two synchroniser stages and the previous-sample stage, so the collision needs exact timing. The stimulus flips one pin and then holds an all-ones write to the event register in the second cycle after that. The write is active at the very edge where the change is detected. A long random phase then mixes slow pin toggles with random writes and reads, and a cycle-accurate reference model checks every edge.

// File: rtl/spe_pkg.sv
// Shared sizes, register addresses and bit positions of the pin event unit.
// Assumes two slots, each owning one 16-bit halfword of every register.
package spe_pkg;
    localparam int PIN_W  = 8;
    localparam int HALF_W = 16;
    localparam int SLOTS  = 2;
    localparam int REG_W  = SLOTS * HALF_W;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_PINS  = 2'd0,
        ADDR_EVENT = 2'd1,
        ADDR_EN    = 2'd2,
        ADDR_NONE  = 2'd3
    } spe_addr_e;

    // pin positions inside a slot byte
    localparam int PIN_RDY  = 0;
    localparam int PIN_BVD1 = 1;
    localparam int PIN_BVD2 = 2;
    localparam int PIN_CD1  = 3;
    localparam int PIN_CD2  = 4;
    localparam int PIN_WP   = 5;
    localparam int PIN_VS2  = 6;
    localparam int PIN_VS1  = 7;

    // ready event positions inside a halfword
    localparam int EV_RDY_LO   = 7;
    localparam int EV_RDY_HI   = 6;
    localparam int EV_RDY_RISE = 5;
    localparam int EV_RDY_FALL = 4;
    localparam int PRESENT_BIT = 0;

    localparam logic [HALF_W-1:0] HALF_STORE = 16'hFF70;
    localparam logic [HALF_W-1:0] HALF_LIVE  = 16'h0080;
    localparam logic [REG_W-1:0]  STORE_MASK = {SLOTS{HALF_STORE}};
    localparam logic [REG_W-1:0]  LIVE_MASK  = {SLOTS{HALF_LIVE}};
endpackage

// File: rtl/spe_sync.sv
// Two-flop synchroniser for a bundle of independent asynchronous pins.
// Assumes each pin is quasi-static, so no bundle coherency is needed.
module spe_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // two sampling stages against metastability
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/spe_slot_detect.sv
// Per-slot event decode: compares the synchronised pins with the previous
// sample, builds the halfword of event set requests, live level flags and
// the pin register view with the card-present flag.
// Assumes the caller gates the outputs until its sample pipeline is filled.
module spe_slot_detect
    import spe_pkg::*;
(
    input  logic [PIN_W-1:0]  cur,
    input  logic [PIN_W-1:0]  prev,
    input  logic              lvl_ok,
    input  logic              edge_ok,
    output logic [HALF_W-1:0] set_half,
    output logic [HALF_W-1:0] live_half,
    output logic [HALF_W-1:0] pin_half
);
    logic rdy_rise;
    logic rdy_fall;

    // ready transitions against the previous sample
    always_comb begin
        rdy_rise = cur[PIN_RDY] & ~prev[PIN_RDY];
        rdy_fall = ~cur[PIN_RDY] & prev[PIN_RDY];
    end

    // sticky event requests for this slot
    always_comb begin
        set_half = '0;
        if (edge_ok) begin
            set_half[HALF_W-1 -: PIN_W] = cur ^ prev;
            set_half[EV_RDY_RISE]       = rdy_rise;
            set_half[EV_RDY_FALL]       = rdy_fall;
        end
        if (lvl_ok) begin
            set_half[EV_RDY_HI] = cur[PIN_RDY];
        end
    end

    // level flag that follows the pin and is never stored
    always_comb begin
        live_half            = '0;
        live_half[EV_RDY_LO] = lvl_ok & ~cur[PIN_RDY];
    end

    // pin register view, card present only with both detects low
    always_comb begin
        pin_half                    = '0;
        pin_half[HALF_W-1 -: PIN_W] = cur;
        pin_half[PRESENT_BIT]       = lvl_ok & ~cur[PIN_CD1] & ~cur[PIN_CD2];
    end
endmodule

// File: rtl/spe_status_bank.sv
// Shared event register with write-one-to-clear and set priority, the
// enable register and the registered interrupt.
// Assumes set requests arrive only on bits inside STORE.
module spe_status_bank #(
    parameter int              W     = 32,
    parameter logic [W-1:0]    STORE = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] live_vec,
    input  logic [W-1:0] clr_vec,
    input  logic         en_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stat_q,
    output logic [W-1:0] stat_rd,
    output logic [W-1:0] en_q,
    output logic         irq
);
    // sticky event bits: clear by ones, hardware set wins
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= ((stat_q & ~clr_vec) | set_vec) & STORE;
    end

    // visible event view including live level flags
    always_comb stat_rd = stat_q | live_vec;

    // enable register
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_we) en_q <= wdata;
    end

    // registered interrupt from all enabled events of both slots
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(stat_rd & en_q);
    end
endmodule

// File: rtl/slot_pin_event_unit.sv
// Top of the dual-slot pin event unit: synchronises both pin bytes, keeps
// a previous sample, decodes events per slot and serves the register port.
// Assumes slot A on the upper halfword and slot B on the lower halfword.
module slot_pin_event_unit
    import spe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIN_W-1:0]  pin_a,
    input  logic [PIN_W-1:0]  pin_b,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    localparam int ALL_PINS = SLOTS * PIN_W;

    logic [ALL_PINS-1:0] pins_raw;
    logic [ALL_PINS-1:0] pins_sync;
    logic [ALL_PINS-1:0] pins_prev;
    logic [2:0]          vld_q;
    logic [REG_W-1:0]    set_w;
    logic [REG_W-1:0]    live_w;
    logic [REG_W-1:0]    pin_reg_w;
    logic [REG_W-1:0]    clr_w;
    logic [REG_W-1:0]    stat_q_w;
    logic [REG_W-1:0]    stat_rd_w;
    logic [REG_W-1:0]    en_w;
    logic                wr_event;
    logic                wr_en;

    assign pins_raw = {pin_a, pin_b};

    spe_sync #(.W(ALL_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_sync)
    );

    // previous synchronised sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) pins_prev <= '0;
        else        pins_prev <= pins_sync;
    end

    // fill tracker: bit1 = sync output real, bit2 = previous sample real
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= {vld_q[1:0], 1'b1};
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        localparam int POS = SLOTS - 1 - s;
        spe_slot_detect u_det (
            .cur       (pins_sync[POS*PIN_W +: PIN_W]),
            .prev      (pins_prev[POS*PIN_W +: PIN_W]),
            .lvl_ok    (vld_q[1]),
            .edge_ok   (vld_q[2]),
            .set_half  (set_w[POS*HALF_W +: HALF_W]),
            .live_half (live_w[POS*HALF_W +: HALF_W]),
            .pin_half  (pin_reg_w[POS*HALF_W +: HALF_W])
        );
    end

    // write decode
    always_comb begin
        wr_event = reg_wr && (reg_addr == ADDR_EVENT);
        wr_en    = reg_wr && (reg_addr == ADDR_EN);
        clr_w    = wr_event ? reg_wdata : '0;
    end

    spe_status_bank #(.W(REG_W), .STORE(STORE_MASK)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_w),
        .live_vec (live_w & LIVE_MASK),
        .clr_vec  (clr_w),
        .en_we    (wr_en),
        .wdata    (reg_wdata),
        .stat_q   (stat_q_w),
        .stat_rd  (stat_rd_w),
        .en_q     (en_w),
        .irq      (irq)
    );

    // read multiplexer
    always_comb begin
        case (reg_addr)
            ADDR_PINS:  reg_rdata = pin_reg_w;
            ADDR_EVENT: reg_rdata = stat_rd_w;
            ADDR_EN:    reg_rdata = en_w;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spe_checker.sv
// Property checker for the pin event unit, bound into the top module.
// Assumes the reset is synchronous and active low.
module spe_checker
    import spe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [PIN_W-1:0]  pin_a,
    input logic [PIN_W-1:0]  pin_b,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              irq,
    input logic [REG_W-1:0]  set_w,
    input logic [REG_W-1:0]  stat_q,
    input logic [REG_W-1:0]  stat_rd,
    input logic [REG_W-1:0]  en_q,
    input logic [REG_W-1:0]  pin_reg,
    input logic [2:0]        vld
);
    logic [REG_W-1:0] clr_mask;
    logic             any_on;

    // clear mask and enabled-event summary seen by the checker
    always_comb begin
        clr_mask = (reg_wr && reg_addr == ADDR_EVENT) ? reg_wdata : '0;
        any_on   = |(stat_rd & en_q);
    end

    AST_PIN_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        vld[1] |-> (pin_reg[31:24] == $past(pin_a, 2) && pin_reg[15:8] == $past(pin_b, 2))); // R1
    AST_LIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        vld[1] |-> (stat_rd[23] == !pin_reg[24] && stat_rd[7] == !pin_reg[8])); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_w != '0) |=> ((stat_q & $past(set_w)) == $past(set_w))); // R7
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((stat_q & $past(clr_mask & ~set_w)) == '0)); // R7
    AST_NO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q != '0) |=> (($past(stat_q) & ~$past(clr_mask) & ~stat_q) == '0)); // R7
    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        any_on |=> irq); // R9
    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !any_on |=> !irq); // R9
    AST_NO_EARLY_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !vld[2] |-> ((set_w & 32'hFF30_FF30) == '0)); // R10
endmodule

bind slot_pin_event_unit spe_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_a     (pin_a),
    .pin_b     (pin_b),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .set_w     (set_w),
    .stat_q    (stat_q_w),
    .stat_rd   (stat_rd_w),
    .en_q      (en_w),
    .pin_reg   (pin_reg_w),
    .vld       (vld_q)
);

// File: tb/tb_slot_pin_event_unit.sv
`timescale 1ns/1ps
module tb_slot_pin_event_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_a = 8'hFF;
    logic [7:0]  pin_b = 8'hFF;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    slot_pin_event_unit dut (
        .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // reference model state
    logic [15:0] m_s1, m_s2, m_prev;
    logic [31:0] m_stat, m_mask;
    logic        m_irq;
    int          m_fill;

    function automatic logic [31:0] live_view(logic [15:0] s2, int fill);
        logic [31:0] v = '0;
        if (fill >= 2) begin
            v[23] = ~s2[8];
            v[7]  = ~s2[0];
        end
        return v;
    endfunction

    function automatic logic [31:0] pin_view(logic [15:0] s2, int fill);
        logic [31:0] v = '0;
        v[31:24] = s2[15:8];
        v[15:8]  = s2[7:0];
        if (fill >= 2) begin
            v[16] = (s2[12:11] == 2'b00);
            v[0]  = (s2[4:3] == 2'b00);
        end
        return v;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // model update on every edge, then compare shortly after it
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_stat = '0; m_mask = '0;
            m_irq = 1'b0; m_fill = 0;
        end else begin
            logic [31:0] set_v, clr_v;
            logic        nirq;
            nirq  = |((m_stat | live_view(m_s2, m_fill)) & m_mask);
            set_v = '0;
            for (int j = 0; j < 2; j++) begin
                int o;
                logic [7:0] c, p;
                o = 16 * (1 - j);
                c = 8'(m_s2 >> (8 * (1 - j)));
                p = 8'(m_prev >> (8 * (1 - j)));
                if (m_fill >= 3) begin
                    for (int k = 0; k < 8; k++) if (c[k] != p[k]) set_v[o+8+k] = 1'b1;
                    if (c[0] && !p[0]) set_v[o+5] = 1'b1;
                    if (!c[0] && p[0]) set_v[o+4] = 1'b1;
                end
                if (m_fill >= 2 && c[0]) set_v[o+6] = 1'b1;
            end
            clr_v  = (reg_wr && reg_addr == 2'd1) ? reg_wdata : '0;
            m_stat = ((m_stat & ~clr_v) | set_v) & 32'hFF70_FF70;
            if (reg_wr && reg_addr == 2'd2) m_mask = reg_wdata;
            m_irq  = nirq;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = {pin_a, pin_b};
            if (m_fill < 3) m_fill++;
        end
        #1;
        case (reg_addr)
            2'd0: check(reg_rdata, pin_view(m_s2, m_fill), "R1 R2 pin register");
            2'd1: check(reg_rdata, m_stat | live_view(m_s2, m_fill), "R3 R4 R5 R6 R7 event register");
            2'd2: check(reg_rdata, m_mask, "R8 enable register");
            default: check(reg_rdata, 32'h0, "R11 unused address");
        endcase
        check({31'b0, irq}, {31'b0, m_irq}, "R9 irq");
    end

    task automatic look(input logic [1:0] a, input logic [31:0] msk, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        @(posedge clk);
        #1;
        check(reg_rdata & msk, exp, tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        reg_addr = 2'd1;
        @(posedge clk); #1;
        check(reg_rdata, 32'h0, "R10 event after reset");
        check({31'b0, irq}, 32'h0, "R10 irq after reset");
        @(negedge clk);
        rst_n = 1'b1;
        reg_addr = 2'd1;
        @(posedge clk); #1;
        check(reg_rdata, 32'h0, "R10 no event at first edge");
        repeat (6) @(negedge clk);
        look(2'd1, 32'hFFFF_FFFF, 32'h0040_0040, "R6 R10 ready-high only");
        wr(2'd2, 32'hFFFF_FFFF);
        look(2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8 enable readback");
        look(2'd3, 32'hFFFF_FFFF, 32'h0, "R11 address 3");
        // full insertion on slot A
        @(negedge clk); pin_a = 8'hE7;
        repeat (3) @(negedge clk);
        look(2'd0, 32'hFFFF_FFFF, 32'hE701_FF00, "R1 R2 slot A present");
        look(2'd1, 32'h1800_0000, 32'h1800_0000, "R3 detect change bits");
        // half insertion
        @(negedge clk); pin_a = 8'hEF;
        repeat (3) @(negedge clk);
        look(2'd0, 32'hFFFF_FFFF, 32'hEF00_FF00, "R2 mismatched detects");
        // slot B ready low
        @(negedge clk); pin_b = 8'hFE;
        repeat (4) @(negedge clk);
        look(2'd1, 32'h0000_0010, 32'h0000_0010, "R4 ready fall slot B");
        wr(2'd1, 32'h0000_00D0);
        look(2'd1, 32'h0000_00F0, 32'h0000_0080, "R5 R6 live low survives write");
        @(negedge clk); pin_b = 8'hFF;
        repeat (4) @(negedge clk);
        look(2'd1, 32'h0000_00E0, 32'h0000_0060, "R4 R5 ready rise slot B");
        // set and clear on the same edge
        wr(2'd1, 32'hFFFF_FFFF);
        @(negedge clk); pin_b = 8'hDF;
        @(negedge clk);
        @(negedge clk);
        reg_addr = 2'd1; reg_wr = 1'b1; reg_wdata = 32'hFFFF_FFFF;
        @(posedge clk); #1;
        check(reg_rdata & 32'h0000_2000, 32'h0000_2000, "R7 set wins over clear");
        @(negedge clk); reg_wr = 1'b0;
        look(2'd1, 32'h0000_2000, 32'h0000_2000, "R7 bit stays after collision");
        wr(2'd1, 32'h0000_2000);
        look(2'd1, 32'h0000_2000, 32'h0, "R7 later clear");
        // random phase
        for (int n = 0; n < 6000; n++) begin
            @(negedge clk);
            reg_wr = 1'b0;
            if ($urandom_range(0, 9) == 0) pin_a = pin_a ^ (8'h1 << $urandom_range(0, 7));
            if ($urandom_range(0, 9) == 0) pin_b = pin_b ^ (8'h1 << $urandom_range(0, 7));
            reg_addr = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 3) == 0) begin
                reg_wr = 1'b1;
                reg_wdata = ($urandom_range(0, 1) == 0) ? 32'hFFFF_FFFF : $urandom;
            end
        end
        @(negedge clk); reg_wr = 1'b0;
        repeat (4) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule